// File: doc/BRIEF.md
# Free-Running Microsecond Timer with Compare Channels

This peripheral keeps a 64-bit count that advances once per microsecond. A prescaler divides the system clock by a fixed ratio to make that rate. Software reads the count as two read-only words. Reading the low word captures the upper half into a shadow register, and a later read of the upper word returns that captured value. The two halves therefore form one coherent snapshot, even when a carry passes between the two reads.

Four compare channels each hold a value that software can read and write. When the low word of the count steps onto a channel's value, that channel's status bit sets. The bit stays set until software writes a 1 to it. The interrupt line is high while any status bit is set.

The register port is a plain word-wide strobe interface. An access can fail for three reasons: a misaligned offset, an offset outside the map, or a write to a counter word. A failed access pulses an error flag. Read data and the error flag both appear on the clock after the strobe.

Top module: `sys_timer_periph`

## Requirements
- R1: After reset the count, the status bits, all four compare values and the interrupt line are zero.
- R2: The count increments by exactly one every CLK_DIV system clocks and holds its value in every other clock.
- R3: A write to the low counter word (offset 0x04) or the high counter word (offset 0x08) leaves the count unchanged and raises the error flag.
- R4: A read of offset 0x04 returns the low half and captures the high half into a shadow register. A read of offset 0x08 returns the shadow register, not the live high half.
- R5: Compare channel n sits at offset 0x0C + 4·n, for n from 0 to 3. The channel stores the full written word and returns it on a read.
- R6: Status bit n (bit n of offset 0x00) sets on the tick where the incremented low half equals compare channel n. The bit then stays set until it is cleared.
- R7: A write to offset 0x00 clears each status bit whose written data bit is 1 and leaves the others unchanged. A match in the same clock wins over the clear.
- R8: The interrupt output equals the OR of the status bits, and it falls in the clock after a write that clears the last set bit.
- R9: An access to an offset of 0x1C or above, or to an offset with bits [1:0] nonzero, reads zero, changes no state and raises the error flag.
- R10: Read data and the error flag are registered: they are valid in the clock after the strobe, and the error flag is a one-clock pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 5 | Byte offset of the access |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | WORD_W | Write data |
| bus_rdata | output | WORD_W | Read data, valid one clock after the read strobe |
| bus_err | output | 1 | Access error pulse, one clock after the strobe |
| irq | output | 1 | Level interrupt, high while any status bit is set |

## Verification
The bench builds the block with WORD_W set to 8 and CLK_DIV set to 3. The count is then 16 bits wide and its low half wraps every 256 ticks, about 770 clocks. This brings a carry into the upper half within reach, so the shadow capture can be tested across that carry. Compare matches also occur within a few dozen clocks. A clock-accurate model of the prescaler, the count, the status bits and the shadow register predicts every read, and it predicts the interrupt level on every cycle.

// File: rtl/stmr_pkg.sv
package stmr_pkg;
  localparam int NUM_CMP = 4;
  localparam int ADDR_W  = 5;

  typedef enum logic [2:0] {
    SEL_CTRL,
    SEL_CLO,
    SEL_CHI,
    SEL_CMP,
    SEL_BAD
  } reg_sel_e;

  // Word-aligned offsets only; anything from 0x1C upward is unmapped.
  function automatic reg_sel_e decode_off(input logic [ADDR_W-1:0] off);
    reg_sel_e s;
    if (off[1:0] != 2'b00) s = SEL_BAD;
    else begin
      case (off[4:2])
        3'd0:                   s = SEL_CTRL;
        3'd1:                   s = SEL_CLO;
        3'd2:                   s = SEL_CHI;
        3'd3, 3'd4, 3'd5, 3'd6: s = SEL_CMP;
        default:                s = SEL_BAD;
      endcase
    end
    return s;
  endfunction

  // Channel index is bits [3:2] of the offset relative to the first compare word.
  function automatic logic [1:0] cmp_index(input logic [ADDR_W-1:0] off);
    logic [ADDR_W-1:0] rel;
    rel = off - ADDR_W'(5'h0C);
    return rel[3:2];
  endfunction
endpackage

// File: rtl/stmr_tick_gen.sv
module stmr_tick_gen #(
  parameter int DIV = 50
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);
  localparam int PW = (DIV > 1) ? $clog2(DIV) : 1;

  logic [PW-1:0] pcnt_q;

  assign tick = (pcnt_q == PW'(DIV - 1));

  always_ff @(posedge clk) begin
    if (!rst_n)    pcnt_q <= '0;
    else if (tick) pcnt_q <= '0;
    else           pcnt_q <= pcnt_q + PW'(1);
  end

  generate
    if (DIV > 1) begin : g_gap
      AST_TICK_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick); // R2
    end
  endgenerate
endmodule

// File: rtl/stmr_count64.sv
module stmr_count64 #(
  parameter int WORD_W = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                tick,
  output logic [2*WORD_W-1:0] cnt_q,
  output logic [WORD_W-1:0]   next_lo
);
  localparam int CNT_W = 2 * WORD_W;

  function automatic logic [CNT_W-1:0] step(input logic [CNT_W-1:0] v);
    return v + CNT_W'(1);
  endfunction

  logic [CNT_W-1:0] cnt_next;
  assign cnt_next = step(cnt_q);
  assign next_lo  = cnt_next[WORD_W-1:0];

  always_ff @(posedge clk) begin
    if (!rst_n)    cnt_q <= '0;
    else if (tick) cnt_q <= cnt_next;
  end

  AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> (cnt_q == $past(cnt_q) + CNT_W'(1))); // R2
  AST_CNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(cnt_q)); // R2
endmodule

// File: rtl/stmr_cmp_bank.sv
module stmr_cmp_bank
  import stmr_pkg::*;
#(
  parameter int WORD_W = 32
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      tick,
  input  logic [WORD_W-1:0]         next_lo,
  input  logic                      cmp_we,
  input  logic [1:0]                cmp_idx,
  input  logic [WORD_W-1:0]         wdata,
  input  logic [NUM_CMP-1:0]        clr_mask,
  output logic [NUM_CMP*WORD_W-1:0] cmp_flat,
  output logic [NUM_CMP-1:0]        status_q,
  output logic [NUM_CMP-1:0]        match_evt
);
  for (genvar i = 0; i < NUM_CMP; i++) begin : g_ch
    logic [WORD_W-1:0] cmp_q;

    always_ff @(posedge clk) begin
      if (!rst_n)                             cmp_q <= '0;
      else if (cmp_we && cmp_idx == 2'(i))    cmp_q <= wdata;
    end

    assign cmp_flat[i*WORD_W +: WORD_W] = cmp_q;
    assign match_evt[i] = tick && (next_lo == cmp_q);

    // A new match wins over a same-cycle clear.
    always_ff @(posedge clk) begin
      if (!rst_n)            status_q[i] <= 1'b0;
      else if (match_evt[i]) status_q[i] <= 1'b1;
      else if (clr_mask[i])  status_q[i] <= 1'b0;
    end

    AST_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (status_q[i] && !clr_mask[i]) |=> status_q[i]); // R6
    AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      match_evt[i] |=> status_q[i]); // R7
  end
endmodule

// File: rtl/sys_timer_periph.sv
module sys_timer_periph
  import stmr_pkg::*;
#(
  parameter int CLK_DIV = 50,
  parameter int WORD_W  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [4:0]        bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [WORD_W-1:0] bus_wdata,
  output logic [WORD_W-1:0] bus_rdata,
  output logic              bus_err,
  output logic              irq
);
  localparam int CNT_W = 2 * WORD_W;

  logic                      tick;
  logic [CNT_W-1:0]          cnt_q;
  logic [WORD_W-1:0]         next_lo;
  logic [NUM_CMP*WORD_W-1:0] cmp_flat;
  logic [NUM_CMP-1:0]        status_q;
  logic [NUM_CMP-1:0]        match_evt;
  logic [WORD_W-1:0]         shadow_q;

  reg_sel_e   sel;
  logic [1:0] idx;
  logic       wr_cmp, wr_stat, wr_cnt, rd_lo, bad_acc;
  logic [NUM_CMP-1:0] clr_mask;
  logic [WORD_W-1:0]  rd_mux;

  assign sel      = decode_off(bus_addr);
  assign idx      = cmp_index(bus_addr);
  assign wr_cmp   = bus_wr && (sel == SEL_CMP);
  assign wr_stat  = bus_wr && (sel == SEL_CTRL);
  assign wr_cnt   = bus_wr && ((sel == SEL_CLO) || (sel == SEL_CHI));
  assign rd_lo    = bus_rd && (sel == SEL_CLO);
  assign bad_acc  = ((bus_wr || bus_rd) && (sel == SEL_BAD)) || wr_cnt;
  assign clr_mask = wr_stat ? bus_wdata[NUM_CMP-1:0] : '0;

  stmr_tick_gen #(.DIV(CLK_DIV)) u_tick (
    .clk(clk), .rst_n(rst_n), .tick(tick)
  );

  stmr_count64 #(.WORD_W(WORD_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .tick(tick), .cnt_q(cnt_q), .next_lo(next_lo)
  );

  stmr_cmp_bank #(.WORD_W(WORD_W)) u_cmp (
    .clk(clk), .rst_n(rst_n), .tick(tick), .next_lo(next_lo),
    .cmp_we(wr_cmp), .cmp_idx(idx), .wdata(bus_wdata), .clr_mask(clr_mask),
    .cmp_flat(cmp_flat), .status_q(status_q), .match_evt(match_evt)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)     shadow_q <= '0;
    else if (rd_lo) shadow_q <= cnt_q[CNT_W-1:WORD_W];
  end

  always_comb begin
    case (sel)
      SEL_CTRL: rd_mux = WORD_W'(status_q);
      SEL_CLO:  rd_mux = cnt_q[WORD_W-1:0];
      SEL_CHI:  rd_mux = shadow_q;
      SEL_CMP:  rd_mux = cmp_flat[idx*WORD_W +: WORD_W];
      default:  rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bus_rdata <= '0;
      bus_err   <= 1'b0;
    end else begin
      bus_rdata <= bus_rd ? rd_mux : '0;
      bus_err   <= bad_acc;
    end
  end

  assign irq = |status_q;

  AST_CNT_RO: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_cnt && !tick) |=> $stable(cnt_q)); // R3
  AST_BAD_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    bad_acc |=> bus_err); // R9
  AST_BAD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && sel == SEL_BAD) |=> (bus_rdata == '0)); // R9
  AST_SHADOW_CAP: assert property (@(posedge clk) disable iff (!rst_n)
    rd_lo |=> (shadow_q == $past(cnt_q[CNT_W-1:WORD_W]))); // R4
  AST_IRQ_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stat && (&bus_wdata[NUM_CMP-1:0]) && match_evt == '0) |=> !irq); // R8
  AST_ERR_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_wr && !bus_rd) |=> !bus_err); // R10
endmodule

// File: tb/test_sys_timer_periph.sv
module test_sys_timer_periph;
  localparam int W   = 8;
  localparam int DIV = 3;

  typedef struct {
    logic [W-1:0] d;
    logic         e;
    bit           chk;
    string        tag;
  } exp_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [4:0]   bus_addr = '0;
  logic         bus_wr = 1'b0, bus_rd = 1'b0;
  logic [W-1:0] bus_wdata = '0;
  logic [W-1:0] bus_rdata;
  logic         bus_err, irq;

  int nvec = 0, nfail = 0;
  exp_t q[$];
  bit acc_prev = 0;

  // reference model state
  int             psc_m = 0;
  logic [2*W-1:0] cnt_m = '0;
  logic [3:0]     st_m = '0;
  logic [W-1:0]   cmp_m [4];
  logic [W-1:0]   sh_m = '0;

  always #4 clk = ~clk;

  sys_timer_periph #(.CLK_DIV(DIV), .WORD_W(W)) i_sys_timer_periph (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .bus_err(bus_err), .irq(irq)
  );

  function automatic bit is_bad(input logic [4:0] a);
    return (a[1:0] != 2'b00) || (a >= 5'h1C);
  endfunction

  function automatic logic [W-1:0] model_read(input logic [4:0] a);
    if (is_bad(a)) return '0;
    case (a)
      5'h00: return W'(st_m);
      5'h04: return cnt_m[W-1:0];
      5'h08: return sh_m;
      default: return cmp_m[(a - 5'h0C) >> 2];
    endcase
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      psc_m <= 0; cnt_m <= '0; st_m <= '0; sh_m <= '0;
      for (int n = 0; n < 4; n++) cmp_m[n] <= '0;
    end else begin
      bit tk;
      logic [W-1:0] nlo;
      logic [3:0] setv, clrv;
      tk   = (psc_m == DIV - 1);
      nlo  = cnt_m[W-1:0] + W'(1);
      setv = '0;
      for (int n = 0; n < 4; n++) if (tk && nlo == cmp_m[n]) setv[n] = 1'b1;
      clrv = (bus_wr && bus_addr == 5'h00) ? bus_wdata[3:0] : 4'h0;
      psc_m <= tk ? 0 : psc_m + 1;
      if (tk) cnt_m <= cnt_m + 1'b1;
      st_m <= (st_m & ~clrv) | setv;
      if (bus_wr && !is_bad(bus_addr) && bus_addr >= 5'h0C)
        cmp_m[(bus_addr - 5'h0C) >> 2] <= bus_wdata;
      if (bus_rd && bus_addr == 5'h04) sh_m <= cnt_m[2*W-1:W];
    end
    acc_prev <= rst_n && (bus_wr || bus_rd);
  end

  // monitor: scoreboard pop plus per-cycle interrupt level (R8, R10)
  always @(negedge clk) begin
    if (acc_prev) begin
      if (q.size() == 0) begin
        nfail++;
        $display("FAIL R10 unexpected access result: actual rdata=%h err=%b expected none", bus_rdata, bus_err);
      end else begin
        exp_t it;
        it = q.pop_front();
        nvec++;
        if (bus_err !== it.e || (it.chk && bus_rdata !== it.d)) begin
          nfail++;
          $display("FAIL %s: actual rdata=%h err=%b expected rdata=%h err=%b",
                   it.tag, bus_rdata, bus_err, it.d, it.e);
        end
      end
    end
    if (rst_n) begin
      nvec++;
      if (irq !== (st_m != 0)) begin
        nfail++;
        $display("FAIL R8 irq level: actual %b expected %b", irq, (st_m != 0));
      end
    end
  end

  task automatic rd(input logic [4:0] a, input string tag);
    exp_t it;
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    it.d = model_read(a); it.e = is_bad(a); it.chk = 1; it.tag = tag;
    q.push_back(it);
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic wr(input logic [4:0] a, input logic [W-1:0] d, input string tag);
    exp_t it;
    @(negedge clk);
    bus_addr = a; bus_wr = 1'b1; bus_wdata = d;
    it.d = '0; it.e = is_bad(a) || a == 5'h04 || a == 5'h08; it.chk = 0; it.tag = tag;
    q.push_back(it);
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic check(input bit ok, input string tag, input int act, input int expv);
    nvec++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, expv);
    end
  endtask

  task automatic finish_run();
    $display("  == %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog: actual hung expected completion");
    finish_run();
  end

  initial begin
    logic [W-1:0] c;
    repeat (4) @(negedge clk);
    check(irq == 1'b0 && bus_err == 1'b0, "R1 reset outputs", int'(irq), 0);
    rst_n = 1'b1;
    // R1 reset values of status, count and compares
    rd(5'h00, "R1 status after reset");
    rd(5'h04, "R1 count low after reset");
    for (int n = 0; n < 4; n++) rd(5'(5'h0C + 4 * n), "R1 compare after reset");
    // R5 compare read/write
    wr(5'h0C, 8'hA5, "R5 write cmp0"); wr(5'h10, 8'h5A, "R5 write cmp1");
    wr(5'h14, 8'hFF, "R5 write cmp2"); wr(5'h18, 8'h01, "R5 write cmp3");
    for (int n = 0; n < 4; n++) rd(5'(5'h0C + 4 * n), "R5 compare readback");
    // R2 count progression under spaced reads
    for (int k = 0; k < 6; k++) begin
      rd(5'h04, "R2 count low");
      repeat (k) @(negedge clk);
    end
    // R3 counter words read-only
    wr(5'h04, 8'h77, "R3 write low word err");
    rd(5'h04, "R3 count unchanged after write");
    wr(5'h08, 8'h33, "R3 write high word err");
    rd(5'h08, "R3 shadow unchanged after write");
    // R9 unmapped and misaligned
    rd(5'h1C, "R9 unmapped read");
    wr(5'h1C, 8'hEE, "R9 unmapped write");
    rd(5'h02, "R9 misaligned read");
    wr(5'h0D, 8'h11, "R9 misaligned write");
    rd(5'h0C, "R9 cmp0 untouched");
    // R6 compare match
    wr(5'h00, 8'h0F, "R7 clear all");
    c = cnt_m[W-1:0] + W'(6);
    wr(5'h0C, c, "R6 arm cmp0");
    repeat (30) @(negedge clk);
    check(irq == 1'b1, "R6 irq after cmp0 match", int'(irq), 1);
    rd(5'h00, "R6 status bit0 set");
    repeat (10) @(negedge clk);
    rd(5'h00, "R6 status sticky");
    // R7 write-1-to-clear
    wr(5'h00, 8'h00, "R7 write zero no change");
    rd(5'h00, "R7 status after zero write");
    wr(5'h00, 8'h01, "R7 clear bit0");
    check(irq == 1'b0, "R8 irq fell after clear", int'(irq), 0);
    rd(5'h00, "R7 status after clear");
    // R6/R7 two channels, selective clear
    c = cnt_m[W-1:0] + W'(8);
    wr(5'h14, c, "R6 arm cmp2"); wr(5'h18, c, "R6 arm cmp3");
    repeat (40) @(negedge clk);
    rd(5'h00, "R6 both bits set");
    wr(5'h00, 8'h08, "R7 clear bit3 only");
    rd(5'h00, "R7 bit2 left set");
    check(irq == 1'b1, "R8 irq held by bit2", int'(irq), 1);
    wr(5'h00, 8'h04, "R7 clear bit2");
    // R4 shadow across a carry
    while (!(cnt_m[W-1:0] == 8'hFE && psc_m == DIV - 1)) @(negedge clk);
    rd(5'h04, "R4 low read before carry");
    repeat (3 * DIV) @(negedge clk);
    check(cnt_m[2*W-1:W] != sh_m, "R4 carry reached", int'(cnt_m[2*W-1:W]), int'(sh_m) + 1);
    rd(5'h08, "R4 high read returns shadow");
    rd(5'h04, "R4 low read after carry");
    rd(5'h08, "R4 high read updated shadow");
    repeat (4) @(negedge clk);
    finish_run();
  end
endmodule